// File: doc/BRIEF.md
# Network Controller Interrupt and Management Register File

This block is the software-facing register side of an Ethernet controller. It keeps the interrupt cause and mask registers and drives one level-sensitive interrupt line to the processor. The DMA engines report events through single-cycle set pulses. Software acknowledges an event by writing zeros into the matching cause bits.

The block also holds a PHY management word. When that word carries the read opcode, a read of it returns a fixed answer with a read-valid flag. The answer depends on the PHY register number held in the word: link and autonegotiation status, or one half of the PHY identifier. No serial management traffic is generated.

The first-receive, current-receive and current-transmit descriptor pointers are stored for readback. A write to the DMA command register produces a one-cycle start pulse for each transmit queue. A port-configuration bit selects a two-byte receive padding mode.

Top module: `eth_ctl_regs`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `tx_start` is 0 and `rx_pad_en` is 0.
- R2: A write to the cause register (offset 0x450) ANDs the written value into the stored cause. Each bit written as 0 is cleared and each bit written as 1 is kept. The cause has 4 bits: bit 0 receive, bit 2 high-priority transmit, bit 3 low-priority transmit. It reads back zero-extended.
- R3: Every bit set in `evt_set` sets the matching cause bit at the next edge. A set pulse that arrives in the same cycle as a clearing write to the cause register wins, and the bit ends up set.
- R4: A write to the mask register (offset 0x458) stores all 32 bits, and they read back unchanged. `irq` equals the OR of the cause bits ANDed with mask bits 3:0. It rises or falls in the cycle after the edge that changes either register.
- R5: The management register is at offset 0x010. Bits 15:0 hold data, bits 25:16 hold the PHY register number, bit 26 is the read opcode and bit 27 is read-valid. With the opcode set and register number 0x021, a read returns 0x0800000C: read-valid, link up (0x0004) and autonegotiation complete (0x0008).
- R6: With the opcode set, register number 0x041 reads as 0x08000141 and register number 0x061 reads as 0x08000E20, the two halves of identifier 0x01410E20. Any other register number reads as 0x08000000.
- R7: With bit 26 of the stored management word clear, a read of the management register returns 0, whatever the other bits hold.
- R8: Pointer registers store and return 32 bits. There are four first-receive pointers at 0x480 + 4·i, four current-receive pointers at 0x4A0 + 4·i and two current-transmit pointers at 0x4E0 + 4·i.
- R9: A read of an unmapped or unaligned offset returns 0. A write to one changes no register and no output.
- R10: A write to the DMA command register (offset 0x448) pulses `tx_start[1]` for one cycle if bit 23 is set and `tx_start[0]` if bit 22 is set. The pulse is due in the cycle after the write edge. The command register reads 0.
- R11: A write to port configuration (offset 0x408) sets `rx_pad_en` to bit 28 of the written value. The flag holds until the next such write. The register reads 0.
- R12: Read data is registered. `bus_rdata` shows the value addressed by a read in the cycle after that read's edge and is 0 in a cycle after no read. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 4 | Cause set pulses from the DMA engines |
| irq | output | 1 | Level interrupt |
| tx_start | output | 2 | Transmit start pulses (1 high queue, 0 low queue) |
| rx_pad_en | output | 1 | Two-byte receive padding enable |

## Verification
Every output of this block changes one edge after the access or event that causes it. Read data, start pulses and the padding flag are registered. The interrupt is an AND-OR of registered cause and mask bits, so it settles in the cycle after a cause or mask update. The bench applies one stimulus per clock, updates its own model of the registers for that clock, and compares all four outputs 2 ns after the following rising edge. Because of this, a result that comes a cycle early or a cycle late, including a set pulse that loses to a clear, shows up as a miscompare.

// File: rtl/eth_ctl_pkg.sv
package eth_ctl_pkg;
    localparam int OFS_MGMT    = 'h010;
    localparam int OFS_PORTCFG = 'h408;
    localparam int OFS_DMACMD  = 'h448;
    localparam int OFS_CAUSE   = 'h450;
    localparam int OFS_MASK    = 'h458;
    localparam int OFS_FRX     = 'h480;
    localparam int OFS_CRX     = 'h4A0;
    localparam int OFS_CTX     = 'h4E0;

    localparam int MG_OP_BIT    = 26;
    localparam int MG_VALID_BIT = 27;
    localparam int MG_SEL_LSB   = 16;
    localparam int MG_SEL_W     = 10;

    localparam logic [MG_SEL_W-1:0] SEL_PHY_STATUS = 10'h021;
    localparam logic [MG_SEL_W-1:0] SEL_PHY_ID_HI  = 10'h041;
    localparam logic [MG_SEL_W-1:0] SEL_PHY_ID_LO  = 10'h061;
    localparam logic [31:0]         PHY_IDENT      = 32'h01410E20;
    localparam logic [15:0]         PHY_STAT_WORD  = 16'h000C;

    localparam int CMD_TXHI_BIT = 23;
    localparam int CMD_TXLO_BIT = 22;
    localparam int PAD_BIT      = 28;
endpackage

// File: rtl/eth_irq_unit.sv
module eth_irq_unit #(
    parameter int CAUSE_W = 4,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cause,
    input  logic               wr_mask,
    input  logic [DW-1:0]      wdata,
    input  logic [CAUSE_W-1:0] evt_set,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [DW-1:0]      mask_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [DW-1:0]      mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cause) begin
            st_d.cause = st_q.cause & wdata[CAUSE_W-1:0];
        end
        // set pulses are merged after the clear so they take priority
        st_d.cause = st_d.cause | evt_set;
        if (wr_mask) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign irq_o   = |(st_q.cause & st_q.mask[CAUSE_W-1:0]);

    // R3: a set pulse is never lost, even against a clearing write
    a_r3_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((st_q.cause & $past(evt_set)) == $past(evt_set)));

    // R2: without a set pulse no cause bit can rise
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set == '0) |=> ((st_q.cause & ~$past(st_q.cause)) == '0));

    // R4: the interrupt only drops after a cause or mask write
    a_r4_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_cause || wr_mask));
endmodule

// File: rtl/eth_mgmt_port.sv
module eth_mgmt_port
    import eth_ctl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_value
);
    typedef struct packed {
        logic [DW-1:0] word;
    } mg_st_t;

    mg_st_t st_d, st_q;
    logic [MG_SEL_W-1:0] sel;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.word[MG_SEL_LSB +: MG_SEL_W];

    always_comb begin
        rd_value = '0;
        if (st_q.word[MG_OP_BIT]) begin
            rd_value[MG_VALID_BIT] = 1'b1;
            unique case (sel)
                SEL_PHY_STATUS: rd_value[15:0] = PHY_STAT_WORD;
                SEL_PHY_ID_HI:  rd_value[15:0] = PHY_IDENT[31:16];
                SEL_PHY_ID_LO:  rd_value[15:0] = PHY_IDENT[15:0];
                default:        rd_value[15:0] = 16'h0000;
            endcase
        end
    end

    // R6: a stored read opcode always yields the valid flag
    a_r6_valid_with_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[MG_OP_BIT]) |=> rd_value[MG_VALID_BIT]);

    // R7: a word stored without the opcode answers zero
    a_r7_zero_without_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[MG_OP_BIT]) |=> (rd_value == '0));
endmodule

// File: rtl/eth_ptr_bank.sv
module eth_ptr_bank #(
    parameter int N    = 4,
    parameter int DW   = 32,
    parameter int AW   = 12,
    parameter int BASE = 'h480
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          hit_o,
    output logic [DW-1:0] rd_value
);
    typedef struct packed {
        logic [N-1:0][DW-1:0] ptr;
    } pb_st_t;

    pb_st_t st_d, st_q;
    logic [N-1:0]          hit;
    logic [N-1:0][DW-1:0]  masked;

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [AW-1:0] ENT_ADDR = AW'(BASE + 4 * i);
        assign hit[i]    = (addr == ENT_ADDR);
        assign masked[i] = hit[i] ? st_q.ptr[i] : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en && hit[i]) begin
                st_d.ptr[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < N; i++) begin
            rd_value = rd_value | masked[i];
        end
    end

    assign hit_o = |hit;

    // R8: pointers only move on a write that lands in this bank
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_o) |=> $stable(st_q.ptr));
endmodule

// File: rtl/eth_ctl_regs.sv
module eth_ctl_regs
    import eth_ctl_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int CAUSE_W = 4,
    parameter int N_RXQ   = 4,
    parameter int N_TXQ   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [CAUSE_W-1:0] evt_set,
    output logic               irq,
    output logic [1:0]         tx_start,
    output logic               rx_pad_en
);
    localparam logic [AW-1:0] A_MGMT  = AW'(OFS_MGMT);
    localparam logic [AW-1:0] A_PCFG  = AW'(OFS_PORTCFG);
    localparam logic [AW-1:0] A_CMD   = AW'(OFS_DMACMD);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);

    typedef struct packed {
        logic          pad;
        logic [1:0]    start;
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic               wr_cause, wr_mask, wr_mgmt, wr_pcfg, wr_cmd;
    logic [CAUSE_W-1:0] cause_v;
    logic [DW-1:0]      mask_v;
    logic [DW-1:0]      mgmt_v;
    logic               frx_hit, crx_hit, ctx_hit;
    logic [DW-1:0]      frx_v, crx_v, ctx_v;
    logic [DW-1:0]      rd_mux;

    assign wr_cause = bus_wr && (bus_addr == A_CAUSE);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);
    assign wr_mgmt  = bus_wr && (bus_addr == A_MGMT);
    assign wr_pcfg  = bus_wr && (bus_addr == A_PCFG);
    assign wr_cmd   = bus_wr && (bus_addr == A_CMD);

    eth_irq_unit #(.CAUSE_W(CAUSE_W), .DW(DW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cause (wr_cause),
        .wr_mask  (wr_mask),
        .wdata    (bus_wdata),
        .evt_set  (evt_set),
        .cause_o  (cause_v),
        .mask_o   (mask_v),
        .irq_o    (irq)
    );

    eth_mgmt_port #(.DW(DW)) u_mgmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_mgmt),
        .wdata    (bus_wdata),
        .rd_value (mgmt_v)
    );

    eth_ptr_bank #(.N(N_RXQ), .DW(DW), .AW(AW), .BASE(OFS_FRX)) u_frx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hit_o    (frx_hit),
        .rd_value (frx_v)
    );

    eth_ptr_bank #(.N(N_RXQ), .DW(DW), .AW(AW), .BASE(OFS_CRX)) u_crx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hit_o    (crx_hit),
        .rd_value (crx_v)
    );

    eth_ptr_bank #(.N(N_TXQ), .DW(DW), .AW(AW), .BASE(OFS_CTX)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hit_o    (ctx_hit),
        .rd_value (ctx_v)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_MGMT)  rd_mux = mgmt_v;
        if (bus_addr == A_CAUSE) rd_mux = DW'(cause_v);
        if (bus_addr == A_MASK)  rd_mux = mask_v;
        if (frx_hit)             rd_mux = frx_v;
        if (crx_hit)             rd_mux = crx_v;
        if (ctx_hit)             rd_mux = ctx_v;
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = bus_rd ? rd_mux : '0;
        st_d.start = wr_cmd ? {bus_wdata[CMD_TXHI_BIT], bus_wdata[CMD_TXLO_BIT]} : 2'b00;
        if (wr_pcfg) begin
            st_d.pad = bus_wdata[PAD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign tx_start  = st_q.start;
    assign rx_pad_en = st_q.pad;

    // R12: a cycle without a read leaves the data bus at zero
    a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R10: start pulses only follow a command write
    a_r10_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start != 2'b00) |-> $past(bus_wr && (bus_addr == A_CMD)));

    // R11: padding flag holds between configuration writes
    a_r11_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_PCFG)) |=> $stable(rx_pad_en));
endmodule

// File: tb/eth_ctl_regs_bench.sv
module eth_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_set = '0;
    logic        irq;
    logic [1:0]  tx_start;
    logic        rx_pad_en;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // behavioural model state
    logic [31:0] m_cause, m_mask, m_mgmt;
    logic        m_pad;
    logic [31:0] m_frx [4];
    logic [31:0] m_crx [4];
    logic [31:0] m_ctx [2];

    always #4 clk = ~clk;

    eth_ctl_regs u_eth_ctl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_set   (evt_set),
        .irq       (irq),
        .tx_start  (tx_start),
        .rx_pad_en (rx_pad_en)
    );

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] v = 32'h0;
        if (a == 'h010) begin
            if (m_mgmt[26]) begin
                v = 32'h0800_0000;
                if (m_mgmt[25:16] == 10'h021) v = v | 32'h000C;
                if (m_mgmt[25:16] == 10'h041) v = v | 32'h0141;
                if (m_mgmt[25:16] == 10'h061) v = v | 32'h0E20;
            end
        end else if (a == 'h450) v = m_cause;
        else if (a == 'h458) v = m_mask;
        else if (a >= 'h480 && a <= 'h48C && a % 4 == 0) v = m_frx[(a - 'h480) / 4];
        else if (a >= 'h4A0 && a <= 'h4AC && a % 4 == 0) v = m_crx[(a - 'h4A0) / 4];
        else if (a >= 'h4E0 && a <= 'h4E4 && a % 4 == 0) v = m_ctx[(a - 'h4E0) / 4];
        return v;
    endfunction

    task automatic expect_eq(input string tag, input string what,
                             input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one bus cycle: drive, advance model, compare after the edge
    task automatic step(input string tag, input int a, input logic r, input logic w,
                        input logic [31:0] d, input logic [3:0] e);
        logic [31:0] x_rdata;
        logic [1:0]  x_start;
        logic        x_irq;
        bus_addr  = 12'(a);
        bus_rd    = r;
        bus_wr    = w;
        bus_wdata = d;
        evt_set   = e;
        x_rdata = r ? model_read(a) : 32'h0;
        x_start = 2'b00;
        if (w) begin
            if (a == 'h010) m_mgmt = d;
            if (a == 'h408) m_pad = d[28];
            if (a == 'h448) x_start = {d[23], d[22]};
            if (a == 'h450) m_cause = m_cause & d;
            if (a == 'h458) m_mask = d;
            if (a >= 'h480 && a <= 'h48C && a % 4 == 0) m_frx[(a - 'h480) / 4] = d;
            if (a >= 'h4A0 && a <= 'h4AC && a % 4 == 0) m_crx[(a - 'h4A0) / 4] = d;
            if (a >= 'h4E0 && a <= 'h4E4 && a % 4 == 0) m_ctx[(a - 'h4E0) / 4] = d;
        end
        m_cause = (m_cause | {28'h0, e}) & 32'hF;
        x_irq = ((m_cause & m_mask & 32'hF) != 0);
        @(posedge clk);
        #2;
        expect_eq(tag, "rdata", bus_rdata, x_rdata);
        expect_eq(tag, "irq", {31'h0, irq}, {31'h0, x_irq});
        expect_eq(tag, "tx_start", {30'h0, tx_start}, {30'h0, x_start});
        expect_eq(tag, "rx_pad_en", {31'h0, rx_pad_en}, {31'h0, m_pad});
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        evt_set = '0;
    endtask

    task automatic wr(input string tag, input int a, input logic [31:0] d);
        step(tag, a, 1'b0, 1'b1, d, 4'h0);
    endtask

    task automatic rd(input string tag, input int a);
        step(tag, a, 1'b1, 1'b0, 32'h0, 4'h0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (25000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        m_cause = 0; m_mask = 0; m_mgmt = 0; m_pad = 0;
        for (int i = 0; i < 4; i++) begin m_frx[i] = 0; m_crx[i] = 0; end
        for (int i = 0; i < 2; i++) m_ctx[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on every register
        step("R1", 'h000, 1'b0, 1'b0, 0, 0);
        rd("R1", 'h010); rd("R1", 'h450); rd("R1", 'h458);
        rd("R1", 'h480); rd("R1", 'h4AC); rd("R1", 'h4E4);

        // R8: pointer banks store and return full words
        for (int i = 0; i < 4; i++) wr("R8", 'h480 + 4 * i, 32'hA000_0010 + i);
        for (int i = 0; i < 4; i++) wr("R8", 'h4A0 + 4 * i, 32'hB000_0100 * (i + 1));
        for (int i = 0; i < 2; i++) wr("R8", 'h4E0 + 4 * i, 32'hC0DE_0000 ^ i);
        for (int i = 0; i < 4; i++) rd("R8", 'h480 + 4 * i);
        for (int i = 0; i < 4; i++) rd("R8", 'h4A0 + 4 * i);
        for (int i = 0; i < 2; i++) rd("R8", 'h4E0 + 4 * i);

        // R3: set pulses raise cause bits
        step("R3", 'h000, 1'b0, 1'b0, 0, 4'b0001);
        step("R3", 'h000, 1'b0, 1'b0, 0, 4'b1100);
        rd("R3", 'h450);

        // R4: mask controls the interrupt level, full-width readback
        wr("R4", 'h458, 32'h0000_0001);
        wr("R4", 'h458, 32'h0000_0000);
        wr("R4", 'h458, 32'hFFF0_0004);
        rd("R4", 'h458);

        // R9: unmapped and unaligned offsets
        wr("R9", 'h000, 32'hFFFF_FFFF);
        wr("R9", 'h404, 32'hFFFF_FFFF);
        wr("R9", 'h482, 32'hFFFF_FFFF);
        wr("R9", 'h452, 32'h0);
        wr("R9", 'hFFC, 32'h0);
        rd("R9", 'h000); rd("R9", 'h482); rd("R9", 'hFFC);
        rd("R9", 'h480); rd("R9", 'h450);

        // R2: AND-clear, ones keep
        wr("R2", 'h450, 32'hFFFF_FFFB);
        rd("R2", 'h450);
        wr("R2", 'h450, 32'hFFFF_FFFF);
        rd("R2", 'h450);
        wr("R2", 'h458, 32'h0000_0009);
        wr("R2", 'h450, 32'h0000_0008);
        wr("R2", 'h450, 32'h0000_0000);

        // R3: set in the same cycle as a clear wins
        step("R3", 'h450, 1'b0, 1'b1, 32'h0, 4'b0001);
        rd("R3", 'h450);
        step("R3", 'h450, 1'b1, 1'b1, 32'h0, 4'b0100);
        rd("R3", 'h450);

        // R5, R6, R7: management answers
        wr("R5", 'h010, 32'h0421_FFFF); rd("R5", 'h010);
        wr("R6", 'h010, 32'h0441_0000); rd("R6", 'h010);
        wr("R6", 'h010, 32'h0461_1234); rd("R6", 'h010);
        wr("R6", 'h010, 32'h0423_0000); rd("R6", 'h010);
        wr("R7", 'h010, 32'h0021_0000); rd("R7", 'h010);
        wr("R7", 'h010, 32'h0BFF_FFFF); rd("R7", 'h010);

        // R10: transmit start pulses
        wr("R10", 'h448, 32'h0080_0000);
        wr("R10", 'h448, 32'h0040_0000);
        wr("R10", 'h448, 32'h00C0_0000);
        wr("R10", 'h448, 32'hFF3F_FFFF);
        rd("R10", 'h448);

        // R11: padding flag
        wr("R11", 'h408, 32'h1000_0000);
        step("R11", 'h000, 1'b0, 1'b0, 0, 0);
        rd("R11", 'h408);
        wr("R11", 'h408, 32'hEFFF_FFFF);

        // R12: read/write collision returns old value, idle reads zero
        step("R12", 'h4E0, 1'b1, 1'b1, 32'h5555_AAAA, 4'h0);
        rd("R12", 'h4E0);
        step("R12", 'h000, 1'b0, 1'b0, 0, 0);

        // mixed traffic across the map
        for (int n = 0; n < 400; n++) begin
            int sel;
            int a;
            sel = int'($urandom_range(0, 9));
            case (sel)
                0: a = 'h010;
                1: a = 'h408;
                2: a = 'h448;
                3: a = 'h450;
                4: a = 'h458;
                5: a = 'h480 + 4 * int'($urandom_range(0, 3));
                6: a = 'h4A0 + 4 * int'($urandom_range(0, 3));
                7: a = 'h4E0 + 4 * int'($urandom_range(0, 1));
                default: a = int'($urandom_range(0, 4095));
            endcase
            step("R2 R3 R4 R12 mix", a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom, 4'($urandom_range(0, 15)));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule